// File: doc/BRIEF.md
# Serial Word Aligner with Lock Detection

This block sits behind a clock-data recovery front end. It receives one sampled line bit each time `bit_en` is high. The line carries 12-bit frames, sent in this order: a start bit of 1, ten payload bits with the least significant first, and a stop bit of 0.

The block does not know where frames begin. It tracks every one of the 12 bit phases at the same time and looks for a phase where a 0 is followed by a 1, repeating word after word. When exactly one phase shows this pattern steadily, the block declares lock. From then on it delivers each received payload word with a one-cycle strobe and produces a recovered word clock.

Lock is reported on an active-low flag. It is lost only after the boundary has been missing repeatedly, and the block then searches again across all phases. The parallel outputs are held quiet in three cases:

- while the block is out of lock;
- while the receive enable is low, which keeps lock;
- while power-down is high, which also discards lock.

Top module: `ser_word_aligner`

## Requirements
- R1: `lock_n` falls only after a 0-to-1 boundary has been seen at the same phase on four consecutive word periods. It has not fallen after three such words, and it is low once the fourth has been seen.
- R2: A boundary at a phase means the bit taken at that phase is 1 and the bit taken just before it is 0. A frame is start=1, payload bit 0 through bit 9, then stop=0.
- R3: Two or more phases may each show a boundary on two or more consecutive words. This is a repetitive multi-transition pattern, for example the payload 0x155 sent again and again. While it persists, `lock_n` stays high.
- R4: Once locked, the block stays locked while the boundary keeps recurring at the locked phase, even if the payload is a repetitive multi-transition pattern.
- R5: While locked, four consecutive word periods without the boundary at the locked phase clear lock, but three do not. Afterwards the block can lock again at a different bit offset.
- R6: While the outputs are active, `word_valid` pulses for one cycle after the start bit of the next frame is taken. In that cycle `word_data` holds the payload of the frame that just ended, with `word_data[i]` being payload bit i. There is no pulse on any other cycle.
- R7: `lock_n` is 1 out of reset and while searching, and 0 while locked.
- R8: While unlocked, or while `rx_enable` is 0, or while `pwr_down` is 1, `word_data` and `word_clk` are 0 and `word_valid` is 0. Setting `rx_enable` to 0 does not clear lock.
- R9: Asserting `pwr_down` clears lock and all search state.
- R10: In the cycle of `word_valid`, `word_clk` equals the inverse of `clk_inv`. It stays in that state for half a word period and is then inverted for the other half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Recovered serial bit |
| pwr_down | input | 1 | Power-down: clears lock and quiets outputs |
| rx_enable | input | 1 | Output enable; lock is kept while low |
| clk_inv | input | 1 | Selects the polarity of `word_clk` |
| word_data | output | 10 | Received payload word |
| word_valid | output | 1 | One-cycle strobe per delivered word |
| word_clk | output | 1 | Recovered word clock |
| lock_n | output | 1 | Active-low lock indicator |

## Verification
The assertions take for granted that `bit_en` qualifies exactly one sampled bit per pulse and that `pwr_down` changes only between bits. They also assume that a true frame stream has its start boundary at a fixed phase, so that a lost boundary is a long run of misses and not a single slip.

The stimulus drives every bit away from the clock edge. It inserts random idle cycles between bits but never splits a bit. It sends only whole 12-bit frames, except for one deliberate 5-bit shift that moves the boundary to a new offset.

// File: rtl/swa_pkg.sv
package swa_pkg;
    localparam int SWA_DATA_W       = 10;
    localparam int SWA_LOCK_WORDS   = 4;
    localparam int SWA_UNLOCK_WORDS = 4;
    localparam int SWA_MULTI_WORDS  = 2;
endpackage

// File: rtl/swa_phase_track.sv
// Shifts in line bits, keeps a free-running phase and one consecutive-hit
// counter for every candidate boundary phase.
module swa_phase_track #(
    parameter int DATA_W      = 10,
    parameter int LOCK_WORDS  = 4,
    parameter int MULTI_WORDS = 2,
    localparam int FRAME_W    = DATA_W + 2,
    localparam int PH_W       = $clog2(FRAME_W),
    localparam int CNT_W      = $clog2(LOCK_WORDS + 1),
    localparam int MC_W       = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               bit_en,
    input  logic               bit_in,
    output logic [PH_W-1:0]    ph_o,
    output logic               edge_o,
    output logic [DATA_W-1:0]  payload_o,
    output logic [FRAME_W-1:0] full_o,
    output logic [MC_W-1:0]    multi_o
);
    typedef struct packed {
        logic [DATA_W:0]                 sr;   // sr[0] newest bit
        logic [PH_W-1:0]                 ph;
        logic [FRAME_W-1:0][CNT_W-1:0]   cnt;
    } trk_t;

    trk_t trk_d, trk_q;
    logic edge_w;
    logic [FRAME_W-1:0][CNT_W-1:0] cnt_nxt;
    logic [FRAME_W-1:0]            seen_w;

    assign edge_w = bit_in & ~trk_q.sr[0];

    for (genvar p = 0; p < FRAME_W; p++) begin : g_pos
        assign full_o[p] = (trk_q.cnt[p] == CNT_W'(LOCK_WORDS));
        assign seen_w[p] = (trk_q.cnt[p] >= CNT_W'(MULTI_WORDS));
        assign cnt_nxt[p] = (trk_q.ph != PH_W'(p)) ? trk_q.cnt[p] :
                            (!edge_w)              ? '0 :
                            full_o[p]              ? trk_q.cnt[p] :
                                                     trk_q.cnt[p] + CNT_W'(1);
    end

    always_comb begin
        multi_o = '0;
        for (int i = 0; i < FRAME_W; i++) begin
            if (seen_w[i]) multi_o = multi_o + MC_W'(1);
        end
    end

    always_comb begin
        trk_d = trk_q;
        if (bit_en) begin
            trk_d.sr  = {trk_q.sr[DATA_W-1:0], bit_in};
            trk_d.ph  = (trk_q.ph == PH_W'(FRAME_W - 1)) ? '0 : trk_q.ph + PH_W'(1);
            trk_d.cnt = cnt_nxt;
        end
        if (clr) trk_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign ph_o      = trk_q.ph;
    assign edge_o    = edge_w;
    assign payload_o = trk_q.sr[DATA_W:1];
endmodule

// File: rtl/swa_lock_ctrl.sv
// Lock acquisition with uniqueness check, and miss counting while locked.
module swa_lock_ctrl #(
    parameter int DATA_W       = 10,
    parameter int UNLOCK_WORDS = 4,
    localparam int FRAME_W     = DATA_W + 2,
    localparam int PH_W        = $clog2(FRAME_W),
    localparam int MC_W        = $clog2(FRAME_W + 1),
    localparam int MISS_W      = $clog2(UNLOCK_WORDS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               bit_en,
    input  logic               edge_i,
    input  logic [PH_W-1:0]    ph_i,
    input  logic [FRAME_W-1:0] full_i,
    input  logic [MC_W-1:0]    multi_i,
    output logic               locked_o,
    output logic [PH_W-1:0]    pos_o,
    output logic               hit_o,
    output logic               unlock_o
);
    typedef struct packed {
        logic              locked;
        logic [PH_W-1:0]   pos;
        logic [MISS_W-1:0] miss;
    } lck_t;

    lck_t lck_d, lck_q;
    logic [PH_W-1:0] idx;

    always_comb begin
        idx = '0;
        for (int i = 0; i < FRAME_W; i++) begin
            if (full_i[i]) idx = PH_W'(i);
        end
    end

    always_comb begin
        lck_d    = lck_q;
        hit_o    = 1'b0;
        unlock_o = 1'b0;
        if (bit_en) begin
            if (!lck_q.locked) begin
                if (multi_i == MC_W'(1) && full_i != '0) begin
                    lck_d.locked = 1'b1;
                    lck_d.pos    = idx;
                    lck_d.miss   = '0;
                end
            end else if (ph_i == lck_q.pos) begin
                if (edge_i) begin
                    lck_d.miss = '0;
                    hit_o      = 1'b1;
                end else if (lck_q.miss == MISS_W'(UNLOCK_WORDS - 1)) begin
                    lck_d    = '0;
                    unlock_o = 1'b1;
                end else begin
                    lck_d.miss = lck_q.miss + MISS_W'(1);
                end
            end
        end
        if (clr) lck_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lck_q <= '0;
        else        lck_q <= lck_d;
    end

    assign locked_o = lck_q.locked;
    assign pos_o    = lck_q.pos;

    // R3: lock is only taken when a single phase shows recurring boundaries
    p_unique_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lck_q.locked) |-> $past(multi_i) == MC_W'(1));

    // R4: a boundary seen at the locked phase keeps lock
    p_hold_on_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lck_q.locked && bit_en && ph_i == lck_q.pos && edge_i && !clr) |=> lck_q.locked);

    // R5: lock drops only after the full run of misses
    p_unlock_after_misses_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lck_q.locked) && !$past(clr)) |->
            ($past(lck_q.miss) == MISS_W'(UNLOCK_WORDS - 1) && !$past(edge_i)));
endmodule

// File: rtl/swa_word_out.sv
// Payload capture, recovered word clock and output quieting.
module swa_word_out #(
    parameter int DATA_W   = 10,
    localparam int FRAME_W = DATA_W + 2,
    localparam int PH_W    = $clog2(FRAME_W),
    localparam int HALF    = FRAME_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bit_en,
    input  logic              hit_i,
    input  logic              locked_i,
    input  logic              rx_en_i,
    input  logic              clk_inv_i,
    input  logic [PH_W-1:0]   ph_i,
    input  logic [PH_W-1:0]   pos_i,
    input  logic [DATA_W-1:0] payload_i,   // payload_i[0] = last payload bit
    output logic [DATA_W-1:0] word_data,
    output logic              word_valid,
    output logic              word_clk
);
    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              stb;
        logic              wclk;
    } out_t;

    out_t out_d, out_q;
    logic [PH_W:0] half_pos;
    logic          on;

    always_comb begin
        half_pos = {1'b0, pos_i} + (PH_W + 1)'(HALF);
        if (half_pos >= (PH_W + 1)'(FRAME_W)) half_pos = half_pos - (PH_W + 1)'(FRAME_W);
    end

    always_comb begin
        out_d     = out_q;
        out_d.stb = 1'b0;
        if (hit_i) begin
            for (int i = 0; i < DATA_W; i++) out_d.word[i] = payload_i[DATA_W - 1 - i];
            out_d.stb  = 1'b1;
            out_d.wclk = 1'b1;
        end else if (bit_en && ph_i == half_pos[PH_W-1:0]) begin
            out_d.wclk = 1'b0;
        end
        if (!locked_i) out_d.wclk = 1'b0;
        if (clr) out_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign on         = locked_i & rx_en_i & ~clr;
    assign word_data  = on ? out_q.word : '0;
    assign word_valid = on & out_q.stb;
    assign word_clk   = on & (out_q.wclk ^ clk_inv_i);

    // R6: a delivered word always follows a qualified bit
    p_valid_after_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(bit_en));
endmodule

// File: rtl/ser_word_aligner.sv
module ser_word_aligner
    import swa_pkg::*;
#(
    parameter int DATA_W       = SWA_DATA_W,
    parameter int LOCK_WORDS   = SWA_LOCK_WORDS,
    parameter int UNLOCK_WORDS = SWA_UNLOCK_WORDS,
    parameter int MULTI_WORDS  = SWA_MULTI_WORDS,
    localparam int FRAME_W     = DATA_W + 2,
    localparam int PH_W        = $clog2(FRAME_W),
    localparam int MC_W        = $clog2(FRAME_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic              pwr_down,
    input  logic              rx_enable,
    input  logic              clk_inv,
    output logic [DATA_W-1:0] word_data,
    output logic              word_valid,
    output logic              word_clk,
    output logic              lock_n
);
    logic [PH_W-1:0]    ph, pos;
    logic               edge_w, hit, unlock, locked;
    logic [DATA_W-1:0]  payload;
    logic [FRAME_W-1:0] full;
    logic [MC_W-1:0]    multi;

    swa_phase_track #(
        .DATA_W(DATA_W), .LOCK_WORDS(LOCK_WORDS), .MULTI_WORDS(MULTI_WORDS)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .clr(pwr_down | unlock),
        .bit_en(bit_en), .bit_in(bit_in),
        .ph_o(ph), .edge_o(edge_w), .payload_o(payload),
        .full_o(full), .multi_o(multi)
    );

    swa_lock_ctrl #(
        .DATA_W(DATA_W), .UNLOCK_WORDS(UNLOCK_WORDS)
    ) u_lock (
        .clk(clk), .rst_n(rst_n), .clr(pwr_down),
        .bit_en(bit_en), .edge_i(edge_w), .ph_i(ph),
        .full_i(full), .multi_i(multi),
        .locked_o(locked), .pos_o(pos), .hit_o(hit), .unlock_o(unlock)
    );

    swa_word_out #(
        .DATA_W(DATA_W)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .clr(pwr_down),
        .bit_en(bit_en), .hit_i(hit), .locked_i(locked),
        .rx_en_i(rx_enable), .clk_inv_i(clk_inv),
        .ph_i(ph), .pos_i(pos), .payload_i(payload),
        .word_data(word_data), .word_valid(word_valid), .word_clk(word_clk)
    );

    assign lock_n = ~locked;

    // R1: lock is only gained on a qualified bit
    p_lock_on_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n) |-> $past(bit_en));
endmodule

// File: tb/ser_word_aligner_tb.sv
`timescale 1ns/1ps
module ser_word_aligner_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0, bit_in = 1'b0;
    logic       pwr_down = 1'b0, rx_enable = 1'b1, clk_inv = 1'b0;
    logic [9:0] word_data;
    logic       word_valid, word_clk, lock_n;

    int n_chk = 0, n_fail = 0, n_stb = 0;
    logic [9:0] exp_w = '0, last_w = '0;
    bit exp_ok = 1'b0, last_ok = 1'b0;

    localparam logic [9:0] TRAIN = 10'h01F;   // six ones then six zeros on the line
    localparam logic [9:0] RMT   = 10'h155;

    always #2 clk = ~clk;

    ser_word_aligner u_dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .pwr_down(pwr_down), .rx_enable(rx_enable), .clk_inv(clk_inv),
        .word_data(word_data), .word_valid(word_valid),
        .word_clk(word_clk), .lock_n(lock_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic look();
        if (word_valid) begin
            n_stb++;
            chk(exp_ok && word_data == exp_w, "R6 word", int'(word_data), int'(exp_w));
            chk(word_clk == ~clk_inv, "R10 word_clk", int'(word_clk), int'(~clk_inv));
        end
    endtask

    task automatic send_bit(input logic b, input logic [9:0] lc, input bit lc_ok);
        @(negedge clk);
        look();
        if ($urandom_range(3) == 0) begin
            bit_en = 1'b0;
            @(negedge clk);
            chk(word_valid == 1'b0, "R6 idle", int'(word_valid), 0);
        end
        bit_in = b; bit_en = 1'b1; exp_w = lc; exp_ok = lc_ok;
    endtask

    task automatic send_frame(input logic [9:0] w);
        send_bit(1'b1, last_w, last_ok);
        for (int i = 0; i < 10; i++) send_bit(w[i], '0, 1'b0);
        send_bit(1'b0, '0, 1'b0);
        last_w = w; last_ok = 1'b1;
    endtask

    task automatic send_bits(input logic [11:0] pat, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(pat[i], '0, 1'b0);
        last_ok = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int s0;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        chk(lock_n == 1'b1, "R7 reset lock_n", int'(lock_n), 1);
        chk(word_data == '0 && word_clk == 1'b0 && word_valid == 1'b0, "R8 reset outputs",
            int'(word_data), 0);
        rst_n = 1'b1;

        // R1 / R2: training frames, one boundary per word
        repeat (3) send_frame(TRAIN);
        chk(lock_n == 1'b1, "R1 no lock after 3 words", int'(lock_n), 1);
        send_frame(TRAIN);
        chk(lock_n == 1'b0, "R1 lock after 4 words", int'(lock_n), 0);
        s0 = n_stb;
        repeat (4) send_frame(TRAIN);
        chk(n_stb > s0, "R6 strobes on training", n_stb - s0, 1);

        // R8: outputs quiet with rx_enable low, lock kept
        rx_enable = 1'b0;
        s0 = n_stb;
        repeat (3) send_frame(TRAIN);
        chk(n_stb == s0 && word_data == '0 && word_clk == 1'b0, "R8 rx disabled quiet",
            n_stb - s0, 0);
        chk(lock_n == 1'b0, "R8 lock kept with rx disabled", int'(lock_n), 0);
        rx_enable = 1'b1;

        // R10: inverted word clock
        clk_inv = 1'b1;
        s0 = n_stb;
        repeat (3) send_frame(TRAIN);
        chk(n_stb > s0, "R10 strobes with inverted clock", n_stb - s0, 1);
        clk_inv = 1'b0;

        // R4: repetitive payload does not unlock
        repeat (10) send_frame(RMT);
        chk(lock_n == 1'b0, "R4 locked through repetitive data", int'(lock_n), 0);

        // R5: four missing boundaries unlock, three do not
        send_frame(RMT);
        repeat (3) send_bits(12'h000, 12);
        chk(lock_n == 1'b0, "R5 still locked after 3 misses", int'(lock_n), 0);
        send_bits(12'h000, 12);
        chk(lock_n == 1'b1, "R5 unlocked after 4 misses", int'(lock_n), 1);
        chk(word_data == '0 && word_clk == 1'b0, "R8 quiet when unlocked", int'(word_data), 0);

        // R3: shift by 5 bits, repetitive multi-transition pattern must not lock
        send_bits(12'h000, 5);
        repeat (30) send_frame(RMT);
        chk(lock_n == 1'b1, "R3 no lock on repetitive pattern", int'(lock_n), 1);

        // R5: recovery at the new offset
        s0 = n_stb;
        repeat (8) send_frame(TRAIN);
        chk(lock_n == 1'b0, "R5 relock at new offset", int'(lock_n), 0);
        chk(n_stb > s0, "R5 words after relock", n_stb - s0, 1);

        // R9: power-down clears lock
        pwr_down = 1'b1;
        repeat (2) send_frame(TRAIN);
        chk(lock_n == 1'b1, "R9 power-down unlocks", int'(lock_n), 1);
        chk(word_data == '0 && word_clk == 1'b0 && word_valid == 1'b0, "R8 power-down quiet",
            int'(word_data), 0);
        pwr_down = 1'b0;

        // R1 / R6: random framed payloads
        s0 = n_stb;
        for (int k = 0; k < 150; k++) send_frame(10'($urandom_range(1023)));
        chk(lock_n == 1'b0, "R1 lock on random data", int'(lock_n), 0);
        chk(n_stb - s0 > 100, "R6 random words delivered", n_stb - s0, 100);

        @(negedge clk);
        look();
        summary();
        $finish;
    end
endmodule